// File: doc/BRIEF.md
# Digital Constant-Fraction Pulse Timer

This block timestamps negative-going detector pulses carried in a stream of 12-bit samples to a fraction of a sample period. Each accepted sample is first referred to a programmable baseline, so that a pulse becomes a positive excursion. A shaped signal is then formed from two copies of that value. One copy is delayed by a programmable number of samples. The other is the current value scaled by a programmable fraction, and it is subtracted from the delayed copy. When the leading edge of a pulse drives the shaped signal from negative to non-negative, the two samples on either side of that sign change are interpolated linearly. The interpolation gives an 8-bit fraction of a sample period.

An arming comparator gates the crossing search. The search runs only after the referred sample has exceeded a threshold, and it is abandoned after a fixed window. A programmable dead time after each hit blocks re-arming. The fraction is produced by a sequential divider. The result comes out as a single-cycle strobe, with a 32-bit sample index and the fraction beside it.

The block accepts one sample per clock at full rate. A doubled-rate stream, built by merging two interleaved converters upstream, is therefore handled without change.

Top module: `dcfd_core`

## Requirements
- R1: While rst_ni is low and after its release, before any hit, hit_o is 0 and coarse_o and fine_o are 0.
- R2: For each accepted sample, x = baseline_i − sample_i as a signed value, and the shaped value is s = x(n−D) − floor(fraction_i · x(n) / 256). D is delay_i, where 0 acts as 1 and the maximum is 15. Accepted samples are numbered by a 32-bit wrapping counter that starts at 0 after reset, and coarse_o carries the number of the sample just before the crossing.
- R3: A crossing is an accepted sample whose s1 ≥ 0 while the previous accepted sample had s0 < 0. The value fine_o = min(255, floor(256 · (−s0) / (s1 − s0))).
- R4: hit_o is high for exactly one cycle, and it is seen high right after the 8th rising clock edge that follows the edge accepting the crossing sample.
- R5: The block arms on an accepted sample only if all of these hold: x exceeds threshold_i (taken as unsigned), it is not already armed, the dead-time count is zero and the divider is idle. The arming sample itself is not examined for a crossing. If x never exceeds threshold_i, no hit occurs.
- R6: Once armed, only the next 16 accepted samples are searched. If none of them is a crossing, the block disarms without a hit and can arm again on a later sample.
- R7: A crossing blocks arming for max(dead_i, 4) accepted samples after the crossing sample. Arming also cannot happen before the cycle that follows hit_o.
- R8: A cycle with valid_i low leaves the delay line, the sample count, the window and the dead-time count unchanged. Samples with valid_i high on every cycle are all accepted.
- R9: A crossing whose s1 is exactly 0 saturates fine_o at 255.
- R10: coarse_o and fine_o change only on the edge where hit_o rises, and they hold their values between hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | sample_i carries a new sample |
| sample_i | input | 12 | ADC code; pulses lower the code |
| baseline_i | input | 12 | ADC code of the quiet level |
| threshold_i | input | 12 | Arming level above baseline |
| delay_i | input | 4 | Delay of the shaping copy in samples |
| fraction_i | input | 8 | Scaling of the current sample, in units of 1/256 |
| dead_i | input | 6 | Samples during which re-arming is blocked after a crossing |
| hit_o | output | 1 | One-cycle strobe: the time outputs are new |
| coarse_o | output | 32 | Index of the sample before the crossing |
| fine_o | output | 8 | Interpolated fraction of a sample period |

## Verification
Two events can land on the same cycle. One is the divider issuing its strobe. The other is a new pulse already exceeding the threshold while the dead time has run out. To provoke this, pulses are placed back to back with the shortest dead time and with a sample on every cycle, so that the divider's busy period outlasts the dead time. The bench model lets the follow-up pulse arm no earlier than the cycle after the strobe. Whether that pulse produces a hit, and with which index and fraction, is compared against the model cycle by cycle.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;
  localparam int SAMPLE_W = 12;
  localparam int DLY_W    = 4;   // delay 1..2**DLY_W-1
  localparam int FRAC_W   = 8;
  localparam int WIN_LEN  = 16;
  localparam int DEAD_W   = 6;
  localparam int DEAD_MIN = 4;
  localparam int TS_W     = 32;
  localparam int X_W      = SAMPLE_W + 1;  // baseline-referred value
  localparam int SHP_W    = SAMPLE_W + 2;  // shaped value
  localparam int DEN_W    = SHP_W + 1;     // s1 - s0
endpackage

// File: rtl/dcfd_shaper.sv
module dcfd_shaper
  import dcfd_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int DLY_W_P    = DLY_W,
  parameter int FRAC_W_P   = FRAC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [SAMPLE_W_P-1:0]      sample_i,
  input  logic [SAMPLE_W_P-1:0]      baseline_i,
  input  logic [DLY_W_P-1:0]         delay_i,
  input  logic [FRAC_W_P-1:0]        fraction_i,
  output logic signed [SAMPLE_W_P:0] x_o,
  output logic signed [SAMPLE_W_P+1:0] shaped_o
);
  localparam int XW    = SAMPLE_W_P + 1;
  localparam int SW    = SAMPLE_W_P + 2;
  localparam int DEPTH = (2 ** DLY_W_P) - 1;
  localparam int PW    = XW + FRAC_W_P + 1;

  logic signed [XW-1:0] hist_q [DEPTH];
  logic signed [XW-1:0] delayed;
  logic [DLY_W_P-1:0]   dsel;
  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] scaled;

  assign x_o  = $signed({1'b0, baseline_i}) - $signed({1'b0, sample_i});
  assign dsel = (delay_i == '0) ? DLY_W_P'(1) : delay_i;
  assign delayed = hist_q[dsel - DLY_W_P'(1)];

  assign prod   = $signed({{(PW-XW){x_o[XW-1]}}, x_o})
                * $signed({{(PW-FRAC_W_P){1'b0}}, fraction_i});
  assign scaled = SW'(prod >>> FRAC_W_P);   // floor division by 2**FRAC_W
  assign shaped_o = $signed({{(SW-XW){delayed[XW-1]}}, delayed}) - scaled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else if (valid_i) begin
      hist_q[0] <= x_o;
      for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
    end
  end
endmodule

// File: rtl/dcfd_arm.sv
module dcfd_arm
  import dcfd_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int WIN_LEN_P  = WIN_LEN,
  parameter int DEAD_W_P   = DEAD_W,
  parameter int DEAD_MIN_P = DEAD_MIN,
  parameter int TS_W_P     = TS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic signed [SAMPLE_W_P:0]   x_i,
  input  logic signed [SAMPLE_W_P+1:0] shaped_i,
  input  logic [SAMPLE_W_P-1:0]        threshold_i,
  input  logic [DEAD_W_P-1:0]          dead_i,
  input  logic                         busy_i,
  output logic                         detect_o,
  output logic                         armed_o,
  output logic signed [SAMPLE_W_P+1:0] s0_o,
  output logic signed [SAMPLE_W_P+1:0] s1_o,
  output logic [TS_W_P-1:0]            coarse_o
);
  localparam int SW    = SAMPLE_W_P + 2;
  localparam int WIN_W = $clog2(WIN_LEN_P);

  logic                 armed_q;
  logic [WIN_W-1:0]     win_q;
  logic [DEAD_W_P-1:0]  dead_q, dead_load;
  logic [TS_W_P-1:0]    ts_q;
  logic signed [SW-1:0] sprev_q;
  logic                 arm_go;

  assign detect_o = valid_i && armed_q && sprev_q[SW-1] && !shaped_i[SW-1];
  assign arm_go   = valid_i && !armed_q && (dead_q == '0) && !busy_i
                 && (x_i > $signed({1'b0, threshold_i}));
  assign dead_load = (dead_i < DEAD_W_P'(DEAD_MIN_P)) ? DEAD_W_P'(DEAD_MIN_P) : dead_i;
  assign armed_o  = armed_q;
  assign s0_o     = sprev_q;
  assign s1_o     = shaped_i;
  assign coarse_o = ts_q - TS_W_P'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      win_q   <= '0;
      dead_q  <= '0;
      ts_q    <= '0;
      sprev_q <= '0;
    end else if (valid_i) begin
      ts_q    <= ts_q + TS_W_P'(1);
      sprev_q <= shaped_i;
      if (detect_o) begin
        armed_q <= 1'b0;
        dead_q  <= dead_load;
      end else begin
        if (dead_q != '0) dead_q <= dead_q - DEAD_W_P'(1);
        if (armed_q) begin
          if (win_q == WIN_W'(WIN_LEN_P - 1)) armed_q <= 1'b0;
          win_q <= win_q + WIN_W'(1);
        end else if (arm_go) begin
          armed_q <= 1'b1;
          win_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dcfd_div.sv
module dcfd_div
  import dcfd_pkg::*;
#(
  parameter int SHP_W_P  = SHP_W,
  parameter int FRAC_W_P = FRAC_W,
  parameter int TS_W_P   = TS_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [SHP_W_P-1:0] s0_i,
  input  logic signed [SHP_W_P-1:0] s1_i,
  input  logic [TS_W_P-1:0]         coarse_i,
  output logic                      busy_o,
  output logic                      hit_o,
  output logic [TS_W_P-1:0]         coarse_o,
  output logic [FRAC_W_P-1:0]       fine_o
);
  localparam int DW    = SHP_W_P + 1;
  localparam int CNT_W = $clog2(FRAC_W_P);

  logic signed [DW-1:0] s0x, s1x, num_s, den_s;
  logic [DW-1:0]        rem_q, den_q;
  logic [DW:0]          rem2;
  logic                 ge;
  logic [FRAC_W_P-1:0]  quo_q, quo_nx;
  logic [CNT_W-1:0]     cnt_q;
  logic [TS_W_P-1:0]    coarse_q;

  assign s0x   = {s0_i[SHP_W_P-1], s0_i};
  assign s1x   = {s1_i[SHP_W_P-1], s1_i};
  assign num_s = -s0x;
  assign den_s = s1x - s0x;
  // restoring step; rem <= den holds, so num == den yields all ones (saturation)
  assign rem2   = {rem_q, 1'b0};
  assign ge     = rem2 >= {1'b0, den_q};
  assign quo_nx = {quo_q[FRAC_W_P-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      hit_o    <= 1'b0;
      rem_q    <= '0;
      den_q    <= '0;
      quo_q    <= '0;
      cnt_q    <= '0;
      coarse_q <= '0;
      coarse_o <= '0;
      fine_o   <= '0;
    end else begin
      hit_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o   <= 1'b1;
        rem_q    <= $unsigned(num_s);
        den_q    <= $unsigned(den_s);
        cnt_q    <= '0;
        coarse_q <= coarse_i;
      end else if (busy_o) begin
        rem_q <= ge ? DW'(rem2 - {1'b0, den_q}) : DW'(rem2);
        quo_q <= quo_nx;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(FRAC_W_P - 1)) begin
          busy_o   <= 1'b0;
          hit_o    <= 1'b1;
          fine_o   <= quo_nx;
          coarse_o <= coarse_q;
        end
      end
    end
  end
endmodule

// File: rtl/dcfd_core.sv
module dcfd_core
  import dcfd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] baseline_i,
  input  logic [SAMPLE_W-1:0] threshold_i,
  input  logic [DLY_W-1:0]    delay_i,
  input  logic [FRAC_W-1:0]   fraction_i,
  input  logic [DEAD_W-1:0]   dead_i,
  output logic                hit_o,
  output logic [TS_W-1:0]     coarse_o,
  output logic [FRAC_W-1:0]   fine_o
);
  logic signed [X_W-1:0]   x;
  logic signed [SHP_W-1:0] shaped, s0, s1;
  logic                    det, armed, div_busy;
  logic [TS_W-1:0]         coarse_det;

  dcfd_shaper u_shaper (
    .clk_i, .rst_ni, .valid_i, .sample_i, .baseline_i, .delay_i, .fraction_i,
    .x_o(x), .shaped_o(shaped)
  );

  dcfd_arm u_arm (
    .clk_i, .rst_ni, .valid_i, .x_i(x), .shaped_i(shaped), .threshold_i, .dead_i,
    .busy_i(div_busy), .detect_o(det), .armed_o(armed), .s0_o(s0), .s1_o(s1),
    .coarse_o(coarse_det)
  );

  dcfd_div u_div (
    .clk_i, .rst_ni, .start_i(det), .s0_i(s0), .s1_i(s1), .coarse_i(coarse_det),
    .busy_o(div_busy), .hit_o, .coarse_o, .fine_o
  );
endmodule

// File: rtl/dcfd_core_chk.sv
module dcfd_core_chk
  import dcfd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hit_o,
  input logic [TS_W-1:0]   coarse_o,
  input logic [FRAC_W-1:0] fine_o,
  input logic              det_i,
  input logic              busy_i,
  input logic              armed_i
);
  localparam int LAT = FRAC_W + 1;

  a_r4_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |-> ##LAT hit_o);

  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  a_r6_detect_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> (!armed_i && busy_i));

  a_r7_idle_at_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (!armed_i && !busy_i));

  a_r10_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(hit_o) |-> ($stable(fine_o) && $stable(coarse_o)));
endmodule

bind dcfd_core dcfd_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hit_o(hit_o), .coarse_o(coarse_o), .fine_o(fine_o),
  .det_i(det), .busy_i(div_busy), .armed_i(armed)
);

// File: tb/dcfd_core_tb.sv
module dcfd_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] sample_i = '0, baseline_i = '0, threshold_i = '0;
  logic [3:0]  delay_i = '0;
  logic [7:0]  fraction_i = '0;
  logic [5:0]  dead_i = '0;
  logic        hit_o;
  logic [31:0] coarse_o;
  logic [7:0]  fine_o;

  always #10 clk_i = ~clk_i;

  dcfd_core u_dut (.*);

  typedef struct {int unsigned cyc; int unsigned coarse; int fine;} hit_t;
  hit_t expq[$];
  int n_chk = 0, n_fail = 0, seen = 0, pushed = 0, last_fine = 0;
  int unsigned cyc = 0;
  bit gaps = 0;
  int cfg_d, cfg_f, cfg_thr, cfg_dead, cfg_base;
  int m_hist[15];
  int m_sprev = 0, m_win = 0, m_dead = 0, m_bc = 0;
  bit m_armed = 0;
  int unsigned m_ts = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference from the requirements, evaluated per accepted sample
  function automatic void model_step(bit v, int code, int unsigned edge_no);
    bit set_bc = 0;
    if (v) begin
      int x, s, dd, num, den, fr;
      bit armgo;
      x  = cfg_base - code;
      dd = (cfg_d == 0) ? 1 : cfg_d;
      s  = m_hist[dd-1] - ((cfg_f * x) >>> 8);
      armgo = !m_armed && m_dead == 0 && m_bc == 0 && x > cfg_thr;
      if (m_armed && m_sprev < 0 && s >= 0) begin
        num = -m_sprev; den = s - m_sprev;
        fr = (num * 256) / den;
        if (fr > 255) fr = 255;
        expq.push_back('{edge_no + 8, m_ts - 1, fr});
        pushed++;
        m_armed = 0;
        m_dead = (cfg_dead < 4) ? 4 : cfg_dead;
        m_bc = 8; set_bc = 1;
      end else begin
        if (m_dead > 0) m_dead--;
        if (m_armed) begin
          if (m_win == 15) m_armed = 0;
          m_win++;
        end else if (armgo) begin
          m_armed = 1; m_win = 0;
        end
      end
      for (int k = 14; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = x;
      m_sprev = s;
      m_ts++;
    end
    if (!set_bc && m_bc > 0) m_bc--;
  endfunction

  task automatic check_out();
    if (hit_o) begin
      seen++;
      if (expq.size() == 0 || expq[0].cyc != cyc) begin
        chk(0, "R4 strobe timing", cyc, (expq.size() == 0) ? -1 : expq[0].cyc);
      end else begin
        chk(1, "R4 strobe timing", cyc, expq[0].cyc);
        chk(coarse_o == expq[0].coarse, "R2 coarse index", coarse_o, expq[0].coarse);
        chk(fine_o == expq[0].fine, "R3 fraction", fine_o, expq[0].fine);
        last_fine = fine_o;
        void'(expq.pop_front());
      end
    end else if (expq.size() > 0 && expq[0].cyc == cyc) begin
      chk(0, "R4 missing strobe", 0, 1);
      void'(expq.pop_front());
    end
  endtask

  task automatic tick(bit v, int code);
    valid_i  = v;
    sample_i = code[11:0];
    model_step(v, code, cyc + 1);
    @(posedge clk_i);
    cyc++;
    @(negedge clk_i);
    check_out();
  endtask

  function automatic int clampc(int c);
    return (c < 0) ? 0 : (c > 4095) ? 4095 : c;
  endfunction

  task automatic send(int code);
    if (gaps) while ($urandom_range(0, 3) == 0) tick(0, code);
    tick(1, clampc(code));
  endtask

  function automatic int shape(int k, int amp);
    if (k < 3) return amp * (k + 1) / 3;
    return amp * (10 - k) / 8;
  endfunction

  function automatic int nz(int n);
    return (n == 0) ? 0 : int'($urandom_range(0, 2 * n)) - n;
  endfunction

  task automatic pulse(int amp, int gap, int noise);
    for (int k = 0; k < 11; k++) send(cfg_base - shape(k, amp) + nz(noise));
    for (int k = 0; k < gap; k++) send(cfg_base + nz(noise));
  endtask

  task automatic setcfg(int d, int f, int thr, int dl, int base);
    cfg_d = d; cfg_f = f; cfg_thr = thr; cfg_dead = dl; cfg_base = base;
    delay_i = d[3:0]; fraction_i = f[7:0]; threshold_i = thr[11:0];
    dead_i = dl[5:0]; baseline_i = base[11:0];
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s0, p0;
    void'($urandom(32'd20250611));
    for (int k = 0; k < 15; k++) m_hist[k] = 0;
    setcfg(1, 128, 100, 4, 2000);
    sample_i = 12'd2000;
    repeat (3) @(negedge clk_i);
    chk(hit_o == 0, "R1 hit in reset", hit_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(coarse_o == 0, "R1 coarse after reset", coarse_o, 0);
    chk(fine_o == 0, "R1 fine after reset", fine_o, 0);

    // R9: x steps 0 -> 256 -> 512 with D=1, f=128: s0=-128, s1=0
    repeat (5) send(2000);
    s0 = seen;
    send(2000 - 256); send(2000 - 512);
    repeat (20) send(2000);
    chk(seen - s0 == 1, "R9 hits from exact-zero crossing", seen - s0, 1);
    chk(last_fine == 255, "R9 saturated fraction", last_fine, 255);

    // R5: pulse peaking below threshold
    setcfg(3, 128, 400, 4, 2000);
    s0 = seen;
    pulse(350, 20, 0);
    chk(seen == s0, "R5 sub-threshold pulse ignored", seen - s0, 0);

    // R6: zero fraction never crosses; window expires, then re-arms
    setcfg(3, 0, 100, 4, 2000);
    s0 = seen;
    pulse(1200, 25, 0);
    chk(seen == s0, "R6 expired window gives no hit", seen - s0, 0);
    setcfg(3, 128, 100, 4, 2000);
    pulse(1200, 20, 0);
    chk(seen - s0 == 1, "R6 re-arm after expired window", seen - s0, 1);

    // R7: long dead time suppresses close follow-up pulses
    setcfg(2, 128, 100, 63, 2000);
    s0 = seen; p0 = pushed;
    for (int i = 0; i < 6; i++) pulse(1000, 5, 0);
    repeat (70) send(2000);
    chk(seen - s0 == pushed - p0 && pushed - p0 < 6, "R7 dead time suppression",
        seen - s0, pushed - p0);

    // R7: minimum dead time, back-to-back pulses at full rate; strobe meets re-arm
    setcfg(2, 160, 100, 0, 2000);
    s0 = seen; p0 = pushed;
    for (int i = 0; i < 8; i++) pulse(900 + 100 * i, i % 3, 0);
    repeat (30) send(2000);
    chk(seen - s0 == pushed - p0, "R7 minimum dead time", seen - s0, pushed - p0);

    // R8: random configurations with gaps in valid_i
    gaps = 1;
    for (int c = 0; c < 6; c++) begin
      setcfg($urandom_range(0, 15), $urandom_range(64, 224), $urandom_range(100, 400),
             $urandom_range(0, 63), $urandom_range(1900, 3900));
      s0 = seen; p0 = pushed;
      for (int i = 0; i < 12; i++) pulse($urandom_range(300, 1900), $urandom_range(0, 30), 2);
      repeat (40) send(cfg_base);
      chk(seen - s0 == pushed - p0, "R8 hits with valid gaps", seen - s0, pushed - p0);
    end
    gaps = 0;
    repeat (20) tick(0, cfg_base);
    chk(expq.size() == 0 && seen == pushed, "R4 all expected strobes seen", seen, pushed);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule